// File: doc/BRIEF.md
# Coprocessor Port Window Decoder

This block sits on a byte-wide I/O bus and owns a window of sixteen consecutive port addresses starting at 0x00F0, the ports that belong to the math coprocessor. It keeps two pieces of state: the coprocessor busy latch and the coprocessor-error interrupt request, which drives interrupt line 13. Both are set by a rising edge on the coprocessor error input.

Software uses byte writes into the window to acknowledge a coprocessor error. Every byte write anywhere in the window drops the interrupt request. A byte write to window offset 0 also clears the busy latch, and a byte write to offset 1 sends a one-clock reset pulse to the coprocessor. Everything else that reaches the window counts as an unsupported access and raises a one-clock flag: byte writes to the remaining offsets (which include the opcode-transfer ports), writes wider than a byte, and reads of any width. Reads that hit the window return all ones.

Top module: `cpx_port_dec`

## Requirements
- R1: An access whose address lies outside 0x00F0..0x00FF changes no output: no reset pulse, no unsupported flag, and the interrupt request and busy latch keep their values.
- R2: A rising edge on `cp_err` (high in a cycle after a cycle in which it was low) sets `cp_busy` at the next clock edge. `cp_busy` stays set until a byte write to offset 0 (address 0x00F0).
- R3: A byte write to offset 1 (address 0x00F1) makes `cp_reset` high for exactly the one cycle after the write's clock edge.
- R4: A byte write (`io_width` = 2'b00) to any address in the window deasserts `irq13` at the next clock edge. A rising edge on `cp_err` sets `irq13` at the next clock edge.
- R5: When a rising edge on `cp_err` and a clearing byte write fall in the same cycle, the set wins: `irq13` and `cp_busy` are both high afterwards.
- R6: A byte write to offsets 2 through 15, or a write in the window with `io_width` other than 2'b00 (2'b01 word, 2'b10 double word, 2'b11 also wide), makes `io_unsup` high for one cycle after the edge. A wide write clears neither `irq13` nor `cp_busy` and makes no reset pulse.
- R7: A read in the window, of any width, drives `io_rdata` to 0xFF in the same cycle and makes `io_unsup` high for one cycle after the edge; it leaves `irq13` and `cp_busy` unchanged. When no read hits the window, `io_rdata` is 0x00.
- R8: While `rst_n` is low, `irq13`, `cp_busy`, `cp_reset` and `io_unsup` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_width | input | 2 | Access width: 00 byte, 01 word, 10 double word |
| io_rdata | output | 8 | Read data, 0xFF on a window read |
| cp_err | input | 1 | Coprocessor error level |
| irq13 | output | 1 | Coprocessor error interrupt request |
| cp_busy | output | 1 | Coprocessor busy latch |
| cp_reset | output | 1 | One-cycle coprocessor reset pulse |
| io_unsup | output | 1 | One-cycle unsupported-access flag |

## Verification
The assertions assume that `io_rd` and `io_wr` are never high in the same cycle, and that `cp_err` is already synchronous to `clk`. The random stimulus picks one operation per cycle (idle, read or write), so both strobes are never raised together, and it changes `cp_err` only on the falling clock edge. Addresses fall inside the window about half the time, so every offset and every width is hit often. Directed cases cover an error edge that arrives together with a clearing write, and an access just outside the window.

// File: rtl/cpx_pkg.sv
package cpx_pkg;

    // Access classes produced by the window decoder.
    typedef enum logic [2:0] {
        ACC_NONE      = 3'd0,
        ACC_CLR_BUSY  = 3'd1,
        ACC_CP_RESET  = 3'd2,
        ACC_OTHER_BYT = 3'd3,
        ACC_WIDE_WR   = 3'd4,
        ACC_READ      = 3'd5
    } acc_kind_e;

    // Width code for a single-byte access.
    localparam logic [1:0] WIDTH_BYTE = 2'b00;

    typedef struct packed {
        logic irq;
        logic busy;
        logic cpr;
        logic unsup;
    } ctl_state_t;

    function automatic logic is_byte_write(input acc_kind_e k);
        return (k == ACC_CLR_BUSY) || (k == ACC_CP_RESET) || (k == ACC_OTHER_BYT);
    endfunction

    function automatic logic is_unsupported(input acc_kind_e k);
        return (k == ACC_OTHER_BYT) || (k == ACC_WIDE_WR) || (k == ACC_READ);
    endfunction

endpackage

// File: rtl/cpx_addr_dec.sv
module cpx_addr_dec
    import cpx_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter int              WIN_LOG2  = 4,
    parameter logic [15:0]     BASE      = 16'h00F0,
    parameter int              BUSY_OFF  = 0,
    parameter int              RESET_OFF = 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [1:0]        width_i,
    output logic              hit_o,
    output acc_kind_e         kind_o
);
    localparam int TAG_W = ADDR_W - WIN_LOG2;
    localparam logic [TAG_W-1:0]    BASE_TAG = BASE[ADDR_W-1:WIN_LOG2];
    localparam logic [WIN_LOG2-1:0] OFF_BUSY = WIN_LOG2'(BUSY_OFF);
    localparam logic [WIN_LOG2-1:0] OFF_RST  = WIN_LOG2'(RESET_OFF);

    logic [TAG_W-1:0]    tag;
    logic [WIN_LOG2-1:0] off;

    assign tag   = addr_i[ADDR_W-1:WIN_LOG2];
    assign off   = addr_i[WIN_LOG2-1:0];
    assign hit_o = (tag == BASE_TAG);

    always_comb begin
        kind_o = ACC_NONE;
        if (hit_o) begin
            if (rd_i) begin
                kind_o = ACC_READ;
            end else if (wr_i) begin
                if (width_i != WIDTH_BYTE) begin
                    kind_o = ACC_WIDE_WR;
                end else if (off == OFF_BUSY) begin
                    kind_o = ACC_CLR_BUSY;
                end else if (off == OFF_RST) begin
                    kind_o = ACC_CP_RESET;
                end else begin
                    kind_o = ACC_OTHER_BYT;
                end
            end
        end
    end

endmodule

// File: rtl/cpx_err_edge.sv
module cpx_err_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic err_i,
    output logic rise_o
);
    logic err_d, err_q;

    always_comb begin
        err_d = err_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_d;
    end

    assign rise_o = err_i & ~err_q;

endmodule

// File: rtl/cpx_ctl.sv
module cpx_ctl
    import cpx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  acc_kind_e kind_i,
    input  logic      rise_i,
    output logic      irq_o,
    output logic      busy_o,
    output logic      cpr_o,
    output logic      unsup_o
);
    ctl_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.cpr   = (kind_i == ACC_CP_RESET);
        st_d.unsup = is_unsupported(kind_i);
        if (is_byte_write(kind_i)) st_d.irq = 1'b0;
        if (kind_i == ACC_CLR_BUSY) st_d.busy = 1'b0;
        // An error edge overrides a clear in the same cycle.
        if (rise_i) begin
            st_d.irq  = 1'b1;
            st_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o   = st_q.irq;
    assign busy_o  = st_q.busy;
    assign cpr_o   = st_q.cpr;
    assign unsup_o = st_q.unsup;

    AST_ERR_SETS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        rise_i |=> (irq_o && busy_o)); // R5
    AST_BYTE_WR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (is_byte_write(kind_i) && !rise_i) |=> !irq_o); // R4
    AST_BUSY_ONLY_BY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !rise_i) |=> !busy_o); // R2
    AST_RESET_PULSE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        cpr_o |-> $past(kind_i == ACC_CP_RESET)); // R3
    AST_UNSUP_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        unsup_o |-> $past(is_unsupported(kind_i))); // R6

endmodule

// File: rtl/cpx_port_dec.sv
module cpx_port_dec
    import cpx_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          WIN_LOG2  = 4,
    parameter logic [15:0] BASE      = 16'h00F0,
    parameter int          BUSY_OFF  = 0,
    parameter int          RESET_OFF = 1,
    parameter logic [7:0]  RD_FILL   = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [1:0]        io_width,
    output logic [7:0]        io_rdata,
    input  logic              cp_err,
    output logic              irq13,
    output logic              cp_busy,
    output logic              cp_reset,
    output logic              io_unsup
);
    logic      hit;
    acc_kind_e kind;
    logic      err_rise;

    cpx_addr_dec #(
        .ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .BASE(BASE),
        .BUSY_OFF(BUSY_OFF), .RESET_OFF(RESET_OFF)
    ) u_dec (
        .addr_i(io_addr), .wr_i(io_wr), .rd_i(io_rd), .width_i(io_width),
        .hit_o(hit), .kind_o(kind)
    );

    cpx_err_edge u_edge (
        .clk(clk), .rst_n(rst_n), .err_i(cp_err), .rise_o(err_rise)
    );

    cpx_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .kind_i(kind), .rise_i(err_rise),
        .irq_o(irq13), .busy_o(cp_busy), .cpr_o(cp_reset), .unsup_o(io_unsup)
    );

    assign io_rdata = (hit && io_rd) ? RD_FILL : 8'h00;

    AST_OUTSIDE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> (!cp_reset && !io_unsup)); // R1
    AST_OUTSIDE_KEEPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !err_rise) |=> $stable(irq13)); // R1
    AST_READ_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_READ && !err_rise) |=> ($stable(irq13) && $stable(cp_busy))); // R7

endmodule

// File: tb/cpx_port_dec_tb_top.sv
module cpx_port_dec_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [1:0]  io_width = '0;
    logic [7:0]  io_rdata;
    logic        cp_err = 1'b0;
    logic        irq13, cp_busy, cp_reset, io_unsup;

    int n_chk = 0, n_err = 0, cyc = 0;
    logic m_irq = 0, m_busy = 0, m_rst = 0, m_unsup = 0, m_errq = 0;

    always #10 clk = ~clk;

    cpx_port_dec dut_i (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_width(io_width), .io_rdata(io_rdata), .cp_err(cp_err), .irq13(irq13),
        .cp_busy(cp_busy), .cp_reset(cp_reset), .io_unsup(io_unsup)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic in_win(input logic [15:0] a);
        return a[15:4] == 12'h00F;
    endfunction

    function automatic logic exp_rdata_ff(input logic [15:0] a, input logic rd);
        return in_win(a) && rd;
    endfunction

    // Drive one cycle (called at a falling edge), advance the model, compare after the edge.
    task automatic step(input logic [15:0] a, input logic wr, input logic rd,
                        input logic [1:0] w, input logic err);
        logic hit, bw, rise;
        io_addr = a; io_wr = wr; io_rd = rd; io_width = w; cp_err = err;
        #1;
        chk("R7", "rdata", io_rdata, exp_rdata_ff(a, rd) ? 8'hFF : 8'h00);
        hit  = in_win(a);
        rise = err && !m_errq;
        bw   = hit && wr && !rd && (w == 2'b00);
        m_rst   = bw && (a[3:0] == 4'd1);
        m_unsup = hit && (rd || (wr && (w != 2'b00 || a[3:0] > 4'd1)));
        if (bw) m_irq = 1'b0;
        if (bw && a[3:0] == 4'd0) m_busy = 1'b0;
        if (rise) begin m_irq = 1'b1; m_busy = 1'b1; end
        m_errq = err;
        @(negedge clk);
        chk("R4", "irq13", {7'd0, irq13}, {7'd0, m_irq});
        chk("R2", "cp_busy", {7'd0, cp_busy}, {7'd0, m_busy});
        chk("R3", "cp_reset", {7'd0, cp_reset}, {7'd0, m_rst});
        chk("R6", "io_unsup", {7'd0, io_unsup}, {7'd0, m_unsup});
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8", "irq13", {7'd0, irq13}, 8'd0);
        chk("R8", "cp_busy", {7'd0, cp_busy}, 8'd0);
        chk("R8", "cp_reset", {7'd0, cp_reset}, 8'd0);
        chk("R8", "io_unsup", {7'd0, io_unsup}, 8'd0);
        rst_n = 1'b1;

        // R5: error edge together with a clearing write to offset 0
        step(16'h0000, 0, 0, 2'b00, 0);
        step(16'h00F0, 1, 0, 2'b00, 1);
        chk("R5", "irq13", {7'd0, irq13}, 8'd1);
        chk("R5", "cp_busy", {7'd0, cp_busy}, 8'd1);
        // R1: writes just outside the window do nothing
        step(16'h01F1, 1, 0, 2'b00, 1);
        chk("R1", "cp_reset", {7'd0, cp_reset}, 8'd0);
        chk("R1", "irq13", {7'd0, irq13}, 8'd1);
        step(16'h00EF, 1, 0, 2'b00, 1);
        chk("R1", "io_unsup", {7'd0, io_unsup}, 8'd0);
        // R6: wide write keeps state
        step(16'h00F0, 1, 0, 2'b01, 1);
        chk("R6", "cp_busy", {7'd0, cp_busy}, 8'd1);
        chk("R6", "io_unsup", {7'd0, io_unsup}, 8'd1);
        // R7: read keeps state
        step(16'h00F8, 0, 1, 2'b00, 1);
        chk("R7", "irq13", {7'd0, irq13}, 8'd1);
        // R3: reset pulse lasts one cycle
        step(16'h00F1, 1, 0, 2'b00, 1);
        chk("R3", "cp_reset", {7'd0, cp_reset}, 8'd1);
        step(16'h0000, 0, 0, 2'b00, 1);
        chk("R3", "cp_reset", {7'd0, cp_reset}, 8'd0);

        for (int n = 0; n < 4000; n++) begin
            logic [15:0] a;
            int op;
            a  = ($urandom_range(0, 1) == 0) ? {12'h00F, 4'($urandom_range(0, 15))} : 16'($urandom);
            op = $urandom_range(0, 2);
            step(a, op == 1, op == 2,
                 ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 3)) : 2'b00,
                 ($urandom_range(0, 5) == 0) ? ~cp_err : cp_err);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule